// File: doc/BRIEF.md
# Dual-Channel Gain Code Controller

This block is the digital front end of a two-channel programmable gain stage. It holds one 6-bit gain code per channel. Each code step is 0.25 dB. The code bits are weighted 0.25, 0.5, 1, 2, 4 and 8 dB from bit 0 upward. Code 0 is the lowest gain, nominally 4.5 dB, and each step adds a quarter decibel.

A mode pin decides how the codes are written.

- **Parallel mode:** a 6-bit bus is captured into channel A, channel B or both. The capture is steered by two per-channel load strobes.
- **Serial mode:** the low three bus pins become chip-select, serial data and serial clock. A 12-bit frame then carries both codes at once.

All pins are asynchronous to the system clock. They pass through a synchroniser before any edge is detected.

A global enable pin does not touch the codes. It only drives a disabled flag for the analog side to act on.

Top module: `gain_code_ctrl`

## Requirements
- R1: Each gain code is 6 bits wide. While reset is asserted and after it is released, both codes read 0. The disabled flag reads 1 while reset is asserted.
- R2: `serialMode` low selects parallel loading and `serialMode` high selects serial loading.
- R3: In parallel mode, a rising edge on `loadStrobeA` copies `bitBus` into `gainA` only. `gainB` is left unchanged.
- R4: In parallel mode, a rising edge on `loadStrobeB` copies `bitBus` into `gainB` only. `gainA` is left unchanged.
- R5: In parallel mode, rising edges on both strobes in the same cycle copy the same bus value into both codes.
- R6: In serial mode, edges on either load strobe leave both codes unchanged.
- R7: In serial mode, the pin roles are fixed:
  - `bitBus[0]` is chip-select, active high.
  - `bitBus[1]` is serial data.
  - `bitBus[2]` is serial clock. Data is taken on its rising edge, and only while chip-select is high.
  - `bitBus[5:3]` are ignored.
- R8: A serial frame is 12 bits, sent LSB first: gainA bits 0..5, then gainB bits 0..5. Both codes are updated together when chip-select falls.
- R9: A frame whose bit count is not 12 when chip-select falls is discarded, and both codes keep their values.
- R10: A serial clock rising edge seen in the same synchronised cycle as the chip-select falling edge is not counted as a frame bit.
- R11: `disabled` is 1 while `chipEnable` is low and 0 while it is high. The codes are retained, and loads are still accepted, while disabled.
- R12: In parallel mode, activity on the chip-select, data and clock pin positions without a strobe leaves the codes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serialMode | input | 1 | 1 = serial loading, 0 = parallel loading |
| chipEnable | input | 1 | Global enable; low raises `disabled` |
| bitBus | input | 6 | Parallel code bus; bits 2..0 are clock, data and select in serial mode |
| loadStrobeA | input | 1 | Parallel load strobe for channel A |
| loadStrobeB | input | 1 | Parallel load strobe for channel B |
| gainA | output | 6 | Latched gain code, channel A |
| gainB | output | 6 | Latched gain code, channel B |
| disabled | output | 1 | High while the block is globally disabled |

## Verification
Two pairs of events can land in one synchronised cycle.

The first pair is the two channel strobes. The bench raises both strobes in one assignment, then checks that both codes hold the same bus value.

The second pair is the last serial clock edge and the fall of chip-select. The bench drives both pins in one assignment in two cases:
- After eleven bits, the frame must be discarded.
- After twelve bits, the frame must commit unchanged, because the coincident edge is not counted.

// File: rtl/gain_ctrl_pkg.sv
package gain_ctrl_pkg;
  // Role of the bus pins in serial mode (decoded by the control unit).
  localparam int PIN_SEL  = 0;
  localparam int PIN_SDAT = 1;
  localparam int PIN_SCLK = 2;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic useSerial;
    logic loadA;
    logic loadB;
    logic shiftEn;
    logic shiftBit;
    logic commit;
    logic isDisabled;
  } gainStrobe_t;
endpackage

// File: rtl/gain_ctrl_sync.sv
module gain_ctrl_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stage[0] <= '0;
        else       stage[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) stage[i] <= '0;
        else       stage[i] <= stage[i-1];
      end
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/gain_ctrl_seq.sv
module gain_ctrl_seq
  import gain_ctrl_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialMode,
  input  logic              chipEnable,
  input  logic [CODE_W-1:0] bitBus,
  input  logic              loadStrobeA,
  input  logic              loadStrobeB,
  output gainStrobe_t       strobe,
  output logic [CODE_W-1:0] busData
);
  localparam int FRAME_BITS = 2 * CODE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam int SYNC_W     = CODE_W + 4;
  localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(FRAME_BITS + 1);

  logic [SYNC_W-1:0] rawIn, syncIn;
  logic modeS, enS, strAS, strBS, selS, sdatS, sclkS;
  logic strAPrev, strBPrev, selPrev, sclkPrev;
  logic aRise, bRise, selRise, selFall, sclkRise;
  logic [CNT_W-1:0] bitCount;

  assign rawIn = {chipEnable, serialMode, loadStrobeB, loadStrobeA, bitBus};

  gain_ctrl_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din(rawIn), .dout(syncIn)
  );

  assign busData = syncIn[CODE_W-1:0];
  assign strAS   = syncIn[CODE_W];
  assign strBS   = syncIn[CODE_W+1];
  assign modeS   = syncIn[CODE_W+2];
  assign enS     = syncIn[CODE_W+3];
  assign selS    = busData[PIN_SEL];
  assign sdatS   = busData[PIN_SDAT];
  assign sclkS   = busData[PIN_SCLK];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strAPrev <= 1'b0;
      strBPrev <= 1'b0;
      selPrev  <= 1'b0;
      sclkPrev <= 1'b0;
    end else begin
      strAPrev <= strAS;
      strBPrev <= strBS;
      selPrev  <= selS;
      sclkPrev <= sclkS;
    end
  end

  assign aRise    = strAS & ~strAPrev;
  assign bRise    = strBS & ~strBPrev;
  assign selRise  = selS  & ~selPrev;
  assign selFall  = ~selS & selPrev;
  assign sclkRise = sclkS & ~sclkPrev;

  // Bit counter for the current frame; saturates one past a full frame.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (!modeS || selRise || selFall) begin
      bitCount <= '0;
    end else if (strobe.shiftEn && bitCount != CNT_SAT) begin
      bitCount <= bitCount + 1'b1;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.useSerial  = modeS;
    strobe.loadA      = ~modeS & aRise;
    strobe.loadB      = ~modeS & bRise;
    strobe.shiftEn    = modeS & selS & sclkRise;
    strobe.shiftBit   = sdatS;
    strobe.commit     = modeS & selFall & (bitCount == FRAME_CNT);
    strobe.isDisabled = ~enS;
  end
endmodule

// File: rtl/gain_ctrl_dp.sv
module gain_ctrl_dp
  import gain_ctrl_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  gainStrobe_t       strobe,
  input  logic [CODE_W-1:0] busData,
  output logic [CODE_W-1:0] gainA,
  output logic [CODE_W-1:0] gainB,
  output logic              disabled
);
  localparam int NUM_CH     = 2;
  localparam int FRAME_BITS = NUM_CH * CODE_W;

  logic [FRAME_BITS-1:0] shiftReg;
  logic [CODE_W-1:0]     codeReg [NUM_CH];
  logic [NUM_CH-1:0]     loadVec;

  assign loadVec = {strobe.loadB, strobe.loadA};

  // LSB-first shift: the oldest bit ends up at position 0.
  always_ff @(posedge clk) begin
    if (!rstN)               shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {strobe.shiftBit, shiftReg[FRAME_BITS-1:1]};
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN)              codeReg[ch] <= '0;
      else if (strobe.commit) codeReg[ch] <= shiftReg[ch*CODE_W +: CODE_W];
      else if (loadVec[ch])   codeReg[ch] <= busData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) disabled <= 1'b1;
    else       disabled <= strobe.isDisabled;
  end

  assign gainA = codeReg[0];
  assign gainB = codeReg[1];
endmodule

// File: rtl/gain_code_ctrl.sv
module gain_code_ctrl
  import gain_ctrl_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialMode,
  input  logic              chipEnable,
  input  logic [CODE_W-1:0] bitBus,
  input  logic              loadStrobeA,
  input  logic              loadStrobeB,
  output logic [CODE_W-1:0] gainA,
  output logic [CODE_W-1:0] gainB,
  output logic              disabled
);
  gainStrobe_t       strobe;
  logic [CODE_W-1:0] busData;

  gain_ctrl_seq #(.CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES)) u_seq (
    .clk(clk), .rstN(rstN), .serialMode(serialMode), .chipEnable(chipEnable),
    .bitBus(bitBus), .loadStrobeA(loadStrobeA), .loadStrobeB(loadStrobeB),
    .strobe(strobe), .busData(busData)
  );

  gain_ctrl_dp #(.CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busData(busData),
    .gainA(gainA), .gainB(gainB), .disabled(disabled)
  );
endmodule

// File: rtl/gain_code_ctrl_chk.sv
module gain_code_ctrl_chk
  import gain_ctrl_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input gainStrobe_t       strobe,
  input logic [CODE_W-1:0] gainA,
  input logic [CODE_W-1:0] gainB,
  input logic              disabled
);
  // R8: a frame commit only happens in serial mode
  a_r8_commit_serial: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> strobe.useSerial);

  // R6: parallel loads never issue in serial mode
  a_r6_no_load_serial: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadA || strobe.loadB) |-> !strobe.useSerial);

  // R3: channel A changes only after a load A or a commit
  a_r3_gain_a_cause: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gainA) |-> $past(strobe.loadA || strobe.commit));

  // R4: channel B changes only after a load B or a commit
  a_r4_gain_b_cause: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gainB) |-> $past(strobe.loadB || strobe.commit));

  // R5: a strobe edge is a single-cycle pulse
  a_r5_load_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadA |=> !strobe.loadA);

  // R11: the disabled request reaches the output one cycle later
  a_r11_disabled_follow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.isDisabled |=> disabled);
endmodule

bind gain_code_ctrl gain_code_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .strobe(strobe),
  .gainA(gainA), .gainB(gainB), .disabled(disabled)
);

// File: tb/gain_code_ctrl_bench.sv
module gain_code_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serialMode = 1'b0;
  logic       chipEnable = 1'b0;
  logic [5:0] bitBus = '0;
  logic       loadStrobeA = 1'b0;
  logic       loadStrobeB = 1'b0;
  logic [5:0] gainA, gainB;
  logic       disabled;
  int         nChecks = 0;
  int         nFails = 0;

  always #10 clk = ~clk;

  gain_code_ctrl u_gain_code_ctrl (
    .clk(clk), .rstN(rstN), .serialMode(serialMode), .chipEnable(chipEnable),
    .bitBus(bitBus), .loadStrobeA(loadStrobeA), .loadStrobeB(loadStrobeB),
    .gainA(gainA), .gainB(gainB), .disabled(disabled)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic serBit(input logic b);
    bitBus[1] = b;     settle();
    bitBus[2] = 1'b1;  settle();
    bitBus[2] = 1'b0;  settle();
  endtask

  // n bits of {b,a} LSB first; coinc drives the last clock rise with select fall
  task automatic sendFrame(input logic [5:0] a, input logic [5:0] b,
                           input int n, input bit coinc);
    logic [11:0] frame;
    frame = {b, a};
    bitBus[0] = 1'b1; settle();
    for (int i = 0; i < n; i++) serBit(frame[i % 12]);
    if (coinc) begin
      bitBus[1] = 1'b1;
      settle();
      bitBus[2] = 1'b1;
      bitBus[0] = 1'b0;
      settle();
      bitBus[2] = 1'b0;
    end else begin
      bitBus[0] = 1'b0;
    end
    settle();
  endtask

  task automatic testReset();
    check("R1 gainA at reset", gainA, 0);
    check("R1 gainB at reset", gainB, 0);
    check("R1 disabled in reset", disabled, 1);
    rstN = 1'b1; chipEnable = 1'b1; settle();
    check("R1 gainA after reset", gainA, 0);
    check("R11 enabled flag", disabled, 0);
  endtask

  task automatic testParallel();
    bitBus = 6'h15; settle();
    loadStrobeA = 1'b1; settle(); loadStrobeA = 1'b0; settle();
    check("R3 gainA load", gainA, 6'h15);
    check("R3 gainB untouched", gainB, 0);
    bitBus = 6'h2A; settle();
    loadStrobeB = 1'b1; settle(); loadStrobeB = 1'b0; settle();
    check("R4 gainB load", gainB, 6'h2A);
    check("R4 gainA untouched", gainA, 6'h15);
    bitBus = 6'h3F; settle();
    loadStrobeA = 1'b1; loadStrobeB = 1'b1; settle();
    loadStrobeA = 1'b0; loadStrobeB = 1'b0; settle();
    check("R5 both A", gainA, 63);
    check("R5 both B", gainB, 63);
    bitBus = 6'h07; settle(); bitBus = 6'h06; settle(); bitBus = 6'h00; settle();
    check("R12 pins without strobe A", gainA, 63);
    check("R12 pins without strobe B", gainB, 63);
  endtask

  task automatic testSerial();
    bitBus = '0; settle();
    serialMode = 1'b1; settle();
    bitBus[5:3] = 3'b101;
    sendFrame(6'h0C, 6'h31, 12, 1'b0);
    check("R7 R8 serial A", gainA, 6'h0C);
    check("R8 serial B", gainB, 6'h31);
    loadStrobeA = 1'b1; loadStrobeB = 1'b1; settle();
    loadStrobeA = 1'b0; loadStrobeB = 1'b0; settle();
    check("R6 strobe in serial A", gainA, 6'h0C);
    check("R6 strobe in serial B", gainB, 6'h31);
  endtask

  task automatic testBadFrames();
    sendFrame(6'h01, 6'h02, 11, 1'b0);
    check("R9 short frame A", gainA, 6'h0C);
    sendFrame(6'h01, 6'h02, 13, 1'b0);
    check("R9 long frame B", gainB, 6'h31);
    sendFrame(6'h11, 6'h22, 11, 1'b1);
    check("R10 11 plus coincident A", gainA, 6'h0C);
    sendFrame(6'h11, 6'h22, 12, 1'b1);
    check("R10 12 plus coincident A", gainA, 6'h11);
    check("R10 12 plus coincident B", gainB, 6'h22);
  endtask

  task automatic testDisable();
    chipEnable = 1'b0; settle();
    check("R11 disabled flag", disabled, 1);
    check("R11 code kept", gainA, 6'h11);
    sendFrame(6'h00, 6'h00, 12, 1'b0);
    check("R11 load while disabled", gainB, 0);
    chipEnable = 1'b1; settle();
    check("R11 re-enabled", disabled, 0);
  endtask

  task automatic testModeBack();
    bitBus = '0; serialMode = 1'b0; settle();
    bitBus = 6'h07; settle();
    loadStrobeA = 1'b1; settle(); loadStrobeA = 1'b0; settle();
    check("R2 parallel after serial", gainA, 6'h07);
    check("R2 B kept", gainB, 0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testParallel();
    testSerial();
    testBadFrames();
    testDisable();
    testModeBack();
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end
endmodule